// File: doc/BRIEF.md
# Matrix-Multiplexed Inkjet Nozzle Driver

This block fires the 64 thermal heaters of an inkjet head. The heaters are wired as a matrix of 8 common (COM) lines and 8 segment (SEG) lines. A heater fires only while its COM line and its SEG line are both active. A free-running divider turns the 20 MHz system clock into a 3 kHz column rate.

At the start of each column period the block checks whether the print buffer holds the next column. If it does, the block reads the 64-bit column as eight bytes. It then steps through the eight COM groups one after another. Each group gets a heater pulse with its own SEG pattern, followed by a dead time. If the buffer is not ready, the whole column is skipped with every heater off, and an underrun flag is raised for that period.

The buffer port is a simple registered read port. The block asserts a read enable together with a byte index, and the buffer returns the byte on the following clock.

Top module: `nozzle_matrix_drv`

## Requirements
- R1: Column periods start at the first rising clock edge after reset is released and then every CLK_DIV edges (6667 by default, giving 3 kHz from 20 MHz). The ready input is sampled only on these start edges.
- R2: For a column whose start edge samples `bufReady` high, `bufRdEn` is high for the 8 cycles following the start edge, with `bufRdIdx` counting 0 to 7. Read data is taken from `bufRdata` one cycle after each read.
- R3: While COM group k is active, `seg` carries byte k of the column. Bit j of byte k drives SEG line j, which fires nozzle 8k+j.
- R4: The COM groups fire in order 0 to 7. Each `com[k]` is high for exactly PULSE_CLKS cycles (60). Group k first goes high 9 + 80k cycles after the start edge.
- R5: After each pulse comes a dead time of DEAD_CLKS cycles (20) with all COM lines low. `seg` keeps its value for the first dead cycle and is all zero for the rest of the dead time.
- R6: `seg` changes value only on a clock edge where every COM line was low in the preceding cycle.
- R7: A column whose start edge samples `bufReady` low issues no reads and drives `com` and `seg` to zero for the whole period. `underrun` is high from that start edge until the next start edge. After a ready start edge, `underrun` is low.
- R8: During reset, `com`, `seg`, `bufRdEn` and `underrun` are all zero.
- R9: At most one COM line is active in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (20 MHz nominal) |
| rstN | input | 1 | Active-low synchronous reset |
| bufReady | input | 1 | Print buffer holds the next column; sampled on start edges |
| bufRdEn | output | 1 | Buffer read strobe |
| bufRdIdx | output | 3 | Byte index within the column (COM group number) |
| bufRdata | input | 8 | Byte returned by the buffer one cycle after a read |
| com | output | 8 | COM line drives, one-hot or zero |
| seg | output | 8 | SEG line drives |
| underrun | output | 1 | High for a period whose column was skipped |

## Verification
Some properties are checked by assertions on every cycle:
- no more than one COM line is active at a time;
- SEG changes only while COM is idle;
- the fetch index walks without gaps;
- a pulse always hands over to a dead time;
- a new column starts only from idle;
- COM stays quiet while underrun is flagged.

Other behaviour can only be shown by the bench scenarios, which compare every output cycle by cycle against a timing model over whole columns:
- the exact 3 kHz spacing of the columns;
- the mapping of each byte and bit to the right group and SEG line;
- the pulse and dead-time lengths;
- skipped columns, including consecutive skips and a skip in the first period.

// File: rtl/nzd_pkg.sv
package nzd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_PULSE,
    ST_DEAD
  } drvState_t;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic rdEn;   // issue a buffer read this cycle
    logic comOn;  // drive the selected COM line next cycle
    logic segOn;  // drive the selected group's byte on SEG next cycle
  } drvStrobe_t;

endpackage

// File: rtl/nzd_ctrl.sv
module nzd_ctrl
  import nzd_pkg::*;
#(
  parameter int CLK_DIV    = 6667,
  parameter int NUM_GRP    = 8,
  parameter int PULSE_CLKS = 60,
  parameter int DEAD_CLKS  = 20,
  localparam int GRP_W     = $clog2(NUM_GRP),
  localparam int PH_MAX    = (PULSE_CLKS > DEAD_CLKS) ? PULSE_CLKS : DEAD_CLKS,
  localparam int PH_W      = $clog2(PH_MAX),
  localparam int PC_W      = $clog2(CLK_DIV)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bufReady,
  output drvStrobe_t       strb,
  output logic [GRP_W-1:0] grpIdx,
  output logic             underrun
);

  localparam logic [PC_W-1:0]  PC_LAST    = PC_W'(CLK_DIV - 1);
  localparam logic [GRP_W-1:0] GRP_LAST   = GRP_W'(NUM_GRP - 1);
  localparam logic [PH_W-1:0]  PULSE_LAST = PH_W'(PULSE_CLKS - 1);
  localparam logic [PH_W-1:0]  DEAD_LAST  = PH_W'(DEAD_CLKS - 1);

  logic [PC_W-1:0]  periodCnt;
  logic [PH_W-1:0]  phaseCnt;
  logic [GRP_W-1:0] grpQ;
  drvState_t        stateQ;
  logic             startTick;

  assign startTick = (periodCnt == '0);

  // Column-rate divider
  always_ff @(posedge clk) begin
    if (!rstN) begin
      periodCnt <= '0;
    end else if (periodCnt == PC_LAST) begin
      periodCnt <= '0;
    end else begin
      periodCnt <= periodCnt + PC_W'(1);
    end
  end

  // Underrun flag, decided once per period
  always_ff @(posedge clk) begin
    if (!rstN) begin
      underrun <= 1'b0;
    end else if (startTick) begin
      underrun <= !bufReady;
    end
  end

  // Sequencer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      grpQ     <= '0;
      phaseCnt <= '0;
    end else begin
      unique case (stateQ)
        ST_IDLE: begin
          if (startTick && bufReady) begin
            stateQ <= ST_FETCH;
            grpQ   <= '0;
          end
        end
        ST_FETCH: begin
          if (grpQ == GRP_LAST) begin
            stateQ   <= ST_PULSE;
            grpQ     <= '0;
            phaseCnt <= '0;
          end else begin
            grpQ <= grpQ + GRP_W'(1);
          end
        end
        ST_PULSE: begin
          if (phaseCnt == PULSE_LAST) begin
            stateQ   <= ST_DEAD;
            phaseCnt <= '0;
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        ST_DEAD: begin
          if (phaseCnt == DEAD_LAST) begin
            phaseCnt <= '0;
            if (grpQ == GRP_LAST) begin
              stateQ <= ST_IDLE;
            end else begin
              stateQ <= ST_PULSE;
              grpQ   <= grpQ + GRP_W'(1);
            end
          end else begin
            phaseCnt <= phaseCnt + PH_W'(1);
          end
        end
        default: stateQ <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.rdEn  = (stateQ == ST_FETCH);
    strb.comOn = (stateQ == ST_PULSE);
    strb.segOn = (stateQ == ST_PULSE) || ((stateQ == ST_DEAD) && (phaseCnt == '0));
  end

  assign grpIdx = grpQ;

  // R1: a column can only begin while the sequencer is idle
  a_r1_start_in_idle: assert property (@(posedge clk) disable iff (!rstN)
    (startTick && bufReady) |-> (stateQ == ST_IDLE));

  // R2: fetch index advances by one per read
  a_r2_fetch_walk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_FETCH && grpQ != GRP_LAST) |=>
      (stateQ == ST_FETCH && grpQ == $past(grpQ) + GRP_W'(1)));

  // R4/R5: every pulse is followed by a dead time
  a_r4_pulse_to_dead: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_PULSE && phaseCnt == PULSE_LAST) |=>
      (stateQ == ST_DEAD && phaseCnt == '0));

endmodule

// File: rtl/nzd_datapath.sv
module nzd_datapath
  import nzd_pkg::*;
#(
  parameter int NUM_GRP = 8,
  parameter int SEG_W   = 8,
  localparam int GRP_W  = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  drvStrobe_t         strb,
  input  logic [GRP_W-1:0]   grpIdx,
  output logic               bufRdEn,
  output logic [GRP_W-1:0]   bufRdIdx,
  input  logic [SEG_W-1:0]   bufRdata,
  output logic [NUM_GRP-1:0] comQ,
  output logic [SEG_W-1:0]   segQ
);

  logic               capValid;
  logic [GRP_W-1:0]   capIdx;
  logic [SEG_W-1:0]   colBytes [NUM_GRP];
  logic [NUM_GRP-1:0] comNext;

  assign bufRdEn  = strb.rdEn;
  assign bufRdIdx = grpIdx;

  // Track which byte the buffer returns next cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capValid <= 1'b0;
      capIdx   <= '0;
    end else begin
      capValid <= strb.rdEn;
      capIdx   <= grpIdx;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (!rstN) begin
        colBytes[g] <= '0;
      end else if (capValid && capIdx == GRP_W'(g)) begin
        colBytes[g] <= bufRdata;
      end
    end
  end

  always_comb begin
    comNext = '0;
    if (strb.comOn) comNext[grpIdx] = 1'b1;
  end

  // Registered line drives
  always_ff @(posedge clk) begin
    if (!rstN) begin
      comQ <= '0;
      segQ <= '0;
    end else begin
      comQ <= comNext;
      segQ <= strb.segOn ? colBytes[grpIdx] : '0;
    end
  end

  // R9: never two COM lines at once
  a_r9_single_com: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(comQ));

  // R6: SEG may only move while COM was idle
  a_r6_seg_only_com_idle: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segQ) |-> ($past(comQ) == '0));

endmodule

// File: rtl/nozzle_matrix_drv.sv
module nozzle_matrix_drv
  import nzd_pkg::*;
#(
  parameter int CLK_DIV    = 6667,
  parameter int NUM_GRP    = 8,
  parameter int SEG_W      = 8,
  parameter int PULSE_CLKS = 60,
  parameter int DEAD_CLKS  = 20,
  localparam int GRP_W     = $clog2(NUM_GRP)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bufReady,
  output logic               bufRdEn,
  output logic [GRP_W-1:0]   bufRdIdx,
  input  logic [SEG_W-1:0]   bufRdata,
  output logic [NUM_GRP-1:0] com,
  output logic [SEG_W-1:0]   seg,
  output logic               underrun
);

  drvStrobe_t       strb;
  logic [GRP_W-1:0] grpIdx;

  nzd_ctrl #(
    .CLK_DIV   (CLK_DIV),
    .NUM_GRP   (NUM_GRP),
    .PULSE_CLKS(PULSE_CLKS),
    .DEAD_CLKS (DEAD_CLKS)
  ) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .bufReady(bufReady),
    .strb    (strb),
    .grpIdx  (grpIdx),
    .underrun(underrun)
  );

  nzd_datapath #(
    .NUM_GRP(NUM_GRP),
    .SEG_W  (SEG_W)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .grpIdx  (grpIdx),
    .bufRdEn (bufRdEn),
    .bufRdIdx(bufRdIdx),
    .bufRdata(bufRdata),
    .comQ    (com),
    .segQ    (seg)
  );

  // R7: no heater group fires during a skipped period
  a_r7_quiet_on_underrun: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (com == '0));

endmodule

// File: tb/nozzle_matrix_drv_tb_top.sv
module nozzle_matrix_drv_tb_top;

  localparam int CLK_PERIOD = 50;
  localparam int DIV        = 6667;
  localparam int NCOL       = 18;
  localparam int PULSE      = 60;
  localparam int SLOT       = 80;
  localparam int FIRST      = 9;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bufReady = 1'b0;
  logic       bufRdEn;
  logic [2:0] bufRdIdx;
  logic [7:0] bufRdata = '0;
  logic [7:0] com;
  logic [7:0] seg;
  logic       underrun;
  logic [63:0] curCol = '0;

  int compared = 0;
  int mismatched = 0;
  int printed = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nozzle_matrix_drv dut_i (
    .clk(clk), .rstN(rstN), .bufReady(bufReady),
    .bufRdEn(bufRdEn), .bufRdIdx(bufRdIdx), .bufRdata(bufRdata),
    .com(com), .seg(seg), .underrun(underrun)
  );

  // Registered print buffer model
  always @(posedge clk) begin
    if (bufRdEn) bufRdata <= curCol[bufRdIdx*8 +: 8];
  end

  function automatic logic [7:0] expCom(int t, bit rdy);
    int g;
    if (!rdy || t < FIRST) return 8'h00;
    g = (t - FIRST) / SLOT;
    if (g > 7 || ((t - FIRST) % SLOT) >= PULSE) return 8'h00;
    return 8'h01 << g;
  endfunction

  function automatic logic [7:0] expSeg(int t, bit rdy, logic [63:0] col);
    int g;
    if (!rdy || t < FIRST) return 8'h00;
    g = (t - FIRST) / SLOT;
    if (g > 7 || ((t - FIRST) % SLOT) > PULSE) return 8'h00;
    return col[g*8 +: 8];
  endfunction

  task automatic report(string req, string what, int actual, int expected, int t);
    mismatched++;
    if (printed < 30) begin
      $display("FAIL %s %s at offset %0d: actual %0h expected %0h", req, what, t, actual, expected);
      printed++;
    end
  endtask

  task automatic runColumn(bit rdy, logic [63:0] col);
    logic [7:0] prevCom = com;
    logic [7:0] prevSeg = seg;
    bufReady = rdy;
    curCol   = col;
    for (int t = 0; t < DIV; t++) begin
      logic [7:0] eC;
      logic [7:0] eS;
      bit eRd;
      @(posedge clk);
      @(negedge clk);
      eRd = rdy && (t < 8);
      eC  = expCom(t, rdy);
      eS  = expSeg(t, rdy, col);
      compared++;
      if (bufRdEn !== eRd)
        report((t == 0) ? "R1" : "R2", "bufRdEn", int'(bufRdEn), int'(eRd), t);
      else if (eRd && bufRdIdx !== 3'(t))
        report("R2", "bufRdIdx", int'(bufRdIdx), t, t);
      else if (com !== eC)
        report(rdy ? "R4" : "R7", "com", int'(com), int'(eC), t);
      else if (seg !== eS)
        report((!rdy) ? "R7" : ((eC == 0) ? "R5" : "R3"), "seg", int'(seg), int'(eS), t);
      else if (underrun !== !rdy)
        report("R7", "underrun", int'(underrun), int'(!rdy), t);
      compared++;
      if ($countones(com) > 1)
        report("R9", "com onehot", int'(com), 0, t);
      else if (seg !== prevSeg && prevCom !== 8'h00)
        report("R6", "seg moved under active com", int'(seg), int'(prevSeg), t);
      prevCom = com;
      prevSeg = seg;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: reset state
    compared++;
    if (com !== 8'h00 || seg !== 8'h00 || bufRdEn !== 1'b0 || underrun !== 1'b0)
      report("R8", "reset outputs", int'({com, seg}), 0, -1);
    rstN = 1'b1;
    // Directed corners
    runColumn(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);  // R7 skip in first period
    runColumn(1'b1, 64'hFFFF_FFFF_FFFF_FFFF);  // R3 all nozzles
    runColumn(1'b1, 64'h0000_0000_0000_0000);  // R3 none
    runColumn(1'b1, 64'h8040_2010_0804_0201);  // R3 diagonal bit j of byte j
    runColumn(1'b0, 64'h1234_5678_9ABC_DEF0);  // R7 consecutive skips
    runColumn(1'b0, 64'h0F0F_0F0F_0F0F_0F0F);
    runColumn(1'b1, 64'h5555_AAAA_5555_AAAA);
    for (int n = 7; n < NCOL; n++) begin
      bit rdy = ($urandom_range(3, 0) != 0);
      runColumn(rdy, {$urandom(), $urandom()});
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule